// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block connects a clocked host to one external asynchronous static RAM that holds 64K words of 16 bits and has a separate enable for each byte. The host makes one request at a time: an address, write data, a two-bit byte mask and a read/write select, qualified by a valid/ready pair. The controller then plays out the memory strobes over a fixed number of clock cycles. Read results come back on a data port with a one-cycle valid strobe.

On the memory side the controller drives the address, an active-low chip select, write enable, output enable, and an active-low enable for each byte lane. The data bus is split into an outgoing value, a driver enable and an incoming value, and the pad tristate is built from these three. Every phase lasts a number of clock cycles set by a parameter: the read wait, the write pulse and the idle gap between accesses. Output enable stays high for the whole of a write. This keeps the memory's output drivers off while the controller drives the bus, so the write pulse needs no extra length to let the memory release it.

Top module: `asram_ctl`

## Requirements
- R1: While reset is low and after it is released, req_ready is 1, rsp_valid is 0, mem_dq_oe is 0, and mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n and mem_ub_n are all 1.
- R2: req_ready is 1 only when no access is in progress. A request is taken on a rising edge where req_valid and req_ready are both 1. While req_ready is 0, req_valid is ignored.
- R3: A read starts in the cycle after it is taken and lasts RD_WAIT cycles. During those cycles mem_cs_n and mem_oe_n are 0 and mem_we_n is 1. mem_lb_n is 0 exactly when mask bit 0 is 1, and that lane is bits 7..0. mem_ub_n is 0 exactly when mask bit 1 is 1, and that lane is bits 15..8.
- R4: Read data is sampled on the edge that ends the last read-wait cycle. rsp_valid is then 1 for exactly one cycle. During that cycle chip select and output enable are already 1.
- R5: A byte lane whose mask bit is 0 returns zero in rsp_rdata.
- R6: A write has one setup cycle in which mem_cs_n and the masked byte enables are 0 and mem_we_n is 1. It is followed by WR_PULSE cycles with mem_we_n at 0. mem_oe_n stays 1 for the whole write.
- R7: mem_dq_oe is 1 only while mem_we_n is 0 and at least one byte enable is 0. At those times mem_dq_out carries the request's write data.
- R8: mem_addr equals the request address and does not change in any cycle where mem_cs_n is 0.
- R9: After each access, chip select stays 1 for TURN cycles before req_ready returns. A read therefore occupies RD_WAIT+1+TURN cycles and a write occupies WR_PULSE+1+TURN cycles.
- R10: A masked write changes only the enabled byte. The other byte of that word reads back unchanged.
- R11: With mask 00, no byte enable is asserted and no bus driving takes place. Such a write leaves memory unchanged, and such a read returns zero.
- R12: The controller never drives the data bus while output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Byte mask: bit 0 = bits 7..0, bit 1 = bits 15..8 |
| rsp_valid | output | 1 | One-cycle strobe for read data |
| rsp_rdata | output | 16 | Read data, with disabled lanes set to zero |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Enable for bits 7..0, active low |
| mem_ub_n | output | 1 | Enable for bits 15..8, active low |
| mem_dq_out | output | 16 | Data the controller drives onto the bus |
| mem_dq_oe | output | 1 | Driver enable for mem_dq_out |
| mem_dq_in | input | 16 | Data read back from the bus |

## Verification
The bench models the memory at its pins. This model applies byte-masked writes during the strobe overlap and returns data only on the enabled lanes while output enable is low. The bench also keeps a request-level shadow copy from which it predicts every read. The tests cover partial writes followed by full read-back, masks of 00, address 0 and the top address, and requests held valid while the controller is busy. Each of these targets a specific fault:
- A controller that wrote both lanes regardless of the mask would corrupt the preserved byte.
- One that sampled a cycle early or late, or let the strobe last two cycles, would break the cycle-exact comparison.
- One that accepted a request while busy would shift every later strobe.
- One that left the driver on into the next read, or dropped the idle gap, would show as contention or as missing high chip-select cycles.

// File: rtl/asram_pkg.sv
// Shared types for the asynchronous SRAM controller.
// Assumes a 16-bit memory split into two 8-bit lanes.
package asram_pkg;

    localparam int BYTE_W = 8;
    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_WAIT,
        ST_READ_CAPTURE,
        ST_WRITE_SETUP,
        ST_WRITE_PULSE,
        ST_TURNAROUND
    } asram_state_e;

endpackage

// File: rtl/asram_timer.sv
// Phase down-counter. A load sets the count, the count then
// decreases once per cycle, and expired is high at zero.
// Assumes the loader never loads while the count is still running.
module asram_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Zero marks the last cycle of the phase.
    always_comb begin
        expired = (cnt_q == '0);
    end

endmodule

// File: rtl/asram_seq.sv
// Access sequencer. Walks the phases of one read or one write and
// loads the phase timer with each phase's length minus one.
// Assumes RD_WAIT, WR_PULSE and TURN are each at least 1.
module asram_seq
    import asram_pkg::*;
#(
    parameter int RD_WAIT  = 3,
    parameter int WR_PULSE = 3,
    parameter int TURN     = 1,
    parameter int CNT_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_expired,
    output asram_state_e     state,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture
);

    localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_WAIT - 1);
    localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WR_PULSE - 1);
    localparam logic [CNT_W-1:0] TA_LD = CNT_W'(TURN - 1);

    asram_state_e state_q;
    asram_state_e state_d;

    // Pick the next phase and the timer value for it.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        state_d = ST_WRITE_SETUP;
                    end else begin
                        state_d  = ST_READ_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = RD_LD;
                    end
                end
            end
            ST_READ_WAIT: begin
                if (tmr_expired) begin
                    state_d = ST_READ_CAPTURE;
                end
            end
            ST_READ_CAPTURE: begin
                state_d  = ST_TURNAROUND;
                tmr_load = 1'b1;
                tmr_val  = TA_LD;
            end
            ST_WRITE_SETUP: begin
                state_d  = ST_WRITE_PULSE;
                tmr_load = 1'b1;
                tmr_val  = WP_LD;
            end
            ST_WRITE_PULSE: begin
                if (tmr_expired) begin
                    state_d  = ST_TURNAROUND;
                    tmr_load = 1'b1;
                    tmr_val  = TA_LD;
                end
            end
            ST_TURNAROUND: begin
                if (tmr_expired) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Handshake and sample strobes derived from the current phase.
    always_comb begin
        state   = state_q;
        accept  = (state_q == ST_IDLE) && req_valid;
        capture = (state_q == ST_READ_WAIT) && tmr_expired;
    end

endmodule

// File: rtl/asram_lane.sv
// One byte lane: decodes its active-low enable and holds the byte
// sampled from the bus at the end of a read.
// Assumes capture is a single-cycle strobe.
module asram_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         lane_en,
    input  logic         capture,
    input  logic [W-1:0] dq_in,
    output logic         be_n,
    output logic [W-1:0] rdata
);

    logic [W-1:0] rdata_q;

    // The lane is enabled only during an access whose mask selects it.
    always_comb begin
        be_n  = !(active && lane_en);
        rdata = rdata_q;
    end

    // Sample the bus byte, or zero when the lane is not enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= lane_en ? dq_in : '0;
        end
    end

endmodule

// File: rtl/asram_ctl.sv
// Controller for an external asynchronous static RAM with two byte
// lanes. Takes one host request at a time and plays out the memory
// strobes over cycle counts set by parameters.
// Assumes RD_WAIT, WR_PULSE and TURN are at least 1 and that the
// clock period times each count meets the memory's timing.
module asram_ctl
    import asram_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int RD_WAIT  = 3,
    parameter int WR_PULSE = 3,
    parameter int TURN     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_bmask,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [15:0]       mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [15:0]       mem_dq_in
);

    localparam int MAX_A = (RD_WAIT > WR_PULSE) ? RD_WAIT : WR_PULSE;
    localparam int MAX_C = (MAX_A > TURN) ? MAX_A : TURN;
    localparam int CNT_W = $clog2(MAX_C + 1);

    asram_state_e      state;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              accept;
    logic              capture;
    logic              active;
    logic              rsp_valid_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;
    logic [LANES-1:0]  be_n;

    asram_seq #(
        .RD_WAIT (RD_WAIT),
        .WR_PULSE(WR_PULSE),
        .TURN    (TURN),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .tmr_expired(tmr_expired),
        .state      (state),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .accept     (accept),
        .capture    (capture)
    );

    asram_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    // Hold the request fields for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_bmask;
        end
    end

    // The read-valid strobe follows the sample edge by one register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
        end else begin
            rsp_valid_q <= capture;
        end
    end

    // Chip select covers the read wait and the whole write.
    always_comb begin
        active = (state == ST_READ_WAIT) || (state == ST_WRITE_SETUP) ||
                 (state == ST_WRITE_PULSE);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        asram_lane #(
            .W(BYTE_W)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (active),
            .lane_en(mask_q[g]),
            .capture(capture),
            .dq_in  (mem_dq_in[g*BYTE_W +: BYTE_W]),
            .be_n   (be_n[g]),
            .rdata  (rsp_rdata[g*BYTE_W +: BYTE_W])
        );
    end

    // Memory strobes, decoded from the registered phase.
    always_comb begin
        req_ready  = (state == ST_IDLE);
        rsp_valid  = rsp_valid_q;
        mem_addr   = addr_q;
        mem_cs_n   = !active;
        mem_oe_n   = !(state == ST_READ_WAIT);
        mem_we_n   = !(state == ST_WRITE_PULSE);
        mem_lb_n   = be_n[0];
        mem_ub_n   = be_n[LANES-1];
        mem_dq_out = wdata_q;
        mem_dq_oe  = (state == ST_WRITE_PULSE) && (|mask_q);
    end

endmodule

// File: rtl/asram_ctl_chk.sv
// Protocol checker for asram_ctl, attached by bind. It observes only
// the block's ports and checks strobe ordering and bus ownership.
module asram_ctl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_lb_n,
    input logic              mem_ub_n,
    input logic              mem_dq_oe
);

    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n)); // R2
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R4
    AST_RSP_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (mem_cs_n && mem_oe_n)); // R4
    AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n); // R6
    AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n); // R6
    AST_SELECT_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(!mem_cs_n)); // R6
    AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n); // R7
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R8
    AST_GAP_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs_n) |=> mem_cs_n); // R9
    AST_NO_LANE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lb_n && mem_ub_n) |-> !mem_dq_oe); // R11
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n); // R12

endmodule

bind asram_ctl asram_ctl_chk #(
    .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_addr (mem_addr),
    .mem_cs_n (mem_cs_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_lb_n (mem_lb_n),
    .mem_ub_n (mem_ub_n),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_asram_ctl.sv
// Bench for asram_ctl: a pin-level memory model, a request-level
// shadow and a cycle schedule that is compared on every clock.
module tb_asram_ctl;

    localparam int RD = 3;
    localparam int WP = 3;
    localparam int TG = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_bmask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [15:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in;

    always #2 clk = ~clk;

    asram_ctl #(
        .ADDR_W(16), .RD_WAIT(RD), .WR_PULSE(WP), .TURN(TG)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_bmask(req_bmask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] mem [int];
    logic [15:0] shadow [int];

    function automatic logic [15:0] seed(int a);
        return 16'(a * 40503) ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] mem_rd(int a);
        return mem.exists(a) ? mem[a] : seed(a);
    endfunction

    function automatic logic [15:0] sh_rd(int a);
        return shadow.exists(a) ? shadow[a] : seed(a);
    endfunction

    // Memory model: drives only the enabled lanes while reading.
    always @* begin
        logic [15:0] w;
        w = mem_rd(int'(mem_addr));
        mem_dq_in = 16'h0;
        if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
            if (!mem_lb_n) mem_dq_in[7:0]  = w[7:0];
            if (!mem_ub_n) mem_dq_in[15:8] = w[15:8];
        end
    end

    // Memory model: byte-masked write during the strobe overlap.
    always @(posedge clk) begin
        if (!mem_cs_n && !mem_we_n && mem_dq_oe) begin
            logic [15:0] w;
            w = mem_rd(int'(mem_addr));
            if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
            if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
            mem[int'(mem_addr)] = w;
        end
    end

    // Reference schedule, counted in cycles since the request was taken.
    bit          started = 1'b0;
    bit          busy = 1'b0;
    int          k = 0;
    int          total = 0;
    bit          r_wr = 1'b0;
    logic [15:0] r_addr = '0;
    logic [15:0] r_data = '0;
    logic [1:0]  r_mask = '0;
    logic [15:0] r_exp = '0;
    string       r_tag = "R4";
    string       cur_tag = "R4";

    always @(posedge clk) begin
        bit was_idle;
        started = 1'b1;
        if (!rst_n) begin
            busy = 1'b0;
        end else begin
            was_idle = !busy;
            if (busy) begin
                k++;
                if (k > total) busy = 1'b0;
            end
            if (was_idle && req_valid) begin
                busy   = 1'b1;
                k      = 1;
                r_wr   = req_write;
                r_addr = req_addr;
                r_data = req_wdata;
                r_mask = req_bmask;
                r_tag  = cur_tag;
                total  = req_write ? (WP + 1 + TG) : (RD + 1 + TG);
                if (req_write) begin
                    logic [15:0] w;
                    w = sh_rd(int'(req_addr));
                    if (req_bmask[0]) w[7:0]  = req_wdata[7:0];
                    if (req_bmask[1]) w[15:8] = req_wdata[15:8];
                    shadow[int'(req_addr)] = w;
                end else begin
                    r_exp = sh_rd(int'(req_addr));
                    if (!req_bmask[0]) r_exp[7:0]  = 8'h00;
                    if (!req_bmask[1]) r_exp[15:8] = 8'h00;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            bit erdy, ecs, eoe, ewe, elb, eub, edrv, erv;
            string tc, tb;
            erdy = 1; ecs = 1; eoe = 1; ewe = 1; elb = 1; eub = 1; edrv = 0; erv = 0;
            if (rst_n && busy) begin
                erdy = 0;
                if (!r_wr) begin
                    if (k <= RD) begin
                        ecs = 0; eoe = 0; elb = !r_mask[0]; eub = !r_mask[1];
                    end
                    erv = (k == RD + 1);
                end else if (k <= WP + 1) begin
                    ecs = 0; elb = !r_mask[0]; eub = !r_mask[1];
                    if (k >= 2) begin
                        ewe = 0; edrv = |r_mask;
                    end
                end
            end
            tc = !rst_n ? "R1" : (busy ? (r_wr ? "R6" : "R3") : "R9");
            tb = (rst_n && busy && r_mask == 2'b00) ? "R11" : tc;
            chk(req_ready === erdy, rst_n ? "R2" : "R1", "req_ready", 32'(req_ready), 32'(erdy));
            chk(mem_cs_n === ecs, tc, "mem_cs_n", 32'(mem_cs_n), 32'(ecs));
            chk(mem_oe_n === eoe, tc, "mem_oe_n", 32'(mem_oe_n), 32'(eoe));
            chk(mem_we_n === ewe, tc, "mem_we_n", 32'(mem_we_n), 32'(ewe));
            chk(mem_lb_n === elb, tb, "mem_lb_n", 32'(mem_lb_n), 32'(elb));
            chk(mem_ub_n === eub, tb, "mem_ub_n", 32'(mem_ub_n), 32'(eub));
            chk(mem_dq_oe === edrv, rst_n ? "R7" : "R1", "mem_dq_oe", 32'(mem_dq_oe), 32'(edrv));
            chk(rsp_valid === erv, rst_n ? "R4" : "R1", "rsp_valid", 32'(rsp_valid), 32'(erv));
            chk(!(mem_dq_oe && !mem_oe_n), "R12", "contention", 32'(mem_dq_oe), 32'(0));
            if (rst_n && !mem_cs_n)
                chk(mem_addr === r_addr, "R8", "mem_addr", 32'(mem_addr), 32'(r_addr));
            if (rst_n && mem_dq_oe)
                chk(mem_dq_out === r_data, "R7", "mem_dq_out", 32'(mem_dq_out), 32'(r_data));
            if (erv && rsp_valid)
                chk(rsp_rdata === r_exp, r_tag, "rsp_rdata", 32'(rsp_rdata), 32'(r_exp));
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Present a request and return at the falling edge after it is taken.
    task automatic send(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] m, input string tag);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_bmask = m;
        cur_tag   = tag;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        req_valid = 1'b0;
        req_addr  = 16'hDEAD;
        req_wdata = 16'hBEEF;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual %h expected %h", 32'(0), 32'(1));
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;                                       // R1 checked in and after reset
        repeat (2) @(negedge clk);
        send(1, 16'h00A0, 16'h1234, 2'b11, "R6"); settle();   // word write
        send(0, 16'h00A0, 16'h0000, 2'b11, "R4"); settle();   // word read-back
        send(1, 16'h00A0, 16'h77AB, 2'b01, "R10"); settle();  // low byte only
        send(0, 16'h00A0, 16'h0000, 2'b11, "R10"); settle();  // expect 12AB
        send(1, 16'h00A0, 16'hCD66, 2'b10, "R10"); settle();  // high byte only
        send(0, 16'h00A0, 16'h0000, 2'b11, "R10"); settle();  // expect CDAB
        send(0, 16'h00A0, 16'h0000, 2'b01, "R5"); settle();   // expect 00AB
        send(0, 16'h00A0, 16'h0000, 2'b10, "R5"); settle();   // expect CD00
        send(1, 16'h00A0, 16'hFFFF, 2'b00, "R11"); settle();  // no write
        send(0, 16'h00A0, 16'h0000, 2'b00, "R11"); settle();  // expect 0000
        send(0, 16'h00A0, 16'h0000, 2'b11, "R11"); settle();  // still CDAB
        send(1, 16'h0000, 16'h0F0F, 2'b11, "R8"); settle();   // bottom address
        send(1, 16'hFFFF, 16'hF00D, 2'b11, "R8"); settle();   // top address
        send(0, 16'h0000, 16'h0000, 2'b11, "R8"); settle();
        send(0, 16'hFFFF, 16'h0000, 2'b11, "R8"); settle();
        send(0, 16'h1357, 16'h0000, 2'b11, "R3"); settle();   // unwritten word
        // R2: requests held valid while busy are taken one at a time.
        send(1, 16'h0042, 16'hA1B2, 2'b11, "R2");
        send(0, 16'h0042, 16'h0000, 2'b11, "R2");
        send(1, 16'h0042, 16'h00C3, 2'b01, "R2");
        send(0, 16'h0042, 16'h0000, 2'b11, "R9");
        settle();
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule